// File: doc/BRIEF.md
# NMI Trigger Controller

This block conditions a single non-maskable interrupt input and turns it into one interrupt request for a parent interrupt controller. The raw pin is first brought into the clock domain by a two-stage synchroniser. A programmable trigger code then picks how the pin is judged: low level, high level, falling edge or rising edge. The result is held in a pending flag, and the pending flag is gated by an enable bit before it leaves the block as a registered request.

Software reaches the block through a small memory-mapped register file with an address, a write strobe, write data and combinational read data. There are three registers. A control word holds the trigger code in its two low bits, and its upper bits are free storage. A pending register reads the flag, and writing a one to its bit 0 acknowledges it. An enable register sits at an offset chosen by parameter, either 0x08 or 0x34, to match the integration address. Masking means writing 0 to the enable bit and unmasking means writing 1.

Top module: `nmi_trig_unit`

## Requirements
- R1: After reset the control word reads 0, the enable bit reads 0, the pending flag reads 0 and `irq_out` is low.
- R2: The control word at offset 0x00 is 32 bits of read/write storage. Its bits [1:0] are the trigger code: 0 means active-low level, 1 means falling edge, 2 means active-high level and 3 means rising edge.
- R3: The pin passes through two synchroniser flops. A pin change captured at rising clock edge k changes the pending flag (offset 0x04, bit 0) at edge k+2.
- R4: In the two edge modes (codes 1 and 3), a detected edge sets the pending flag, which then stays set until a write to offset 0x04 with bit 0 = 1. A write with bit 0 = 0 has no effect.
- R5: In the two level modes (codes 0 and 2), the pending flag follows the active level. A clear write drops it for one cycle, and it sets again on the next edge if the level is still active.
- R6: If an edge event and a clear write fall in the same cycle, the flag stays set.
- R7: The enable register holds the enable in bit 0, and its other bits read 0. Writing 0 masks the request and writing 1 unmasks it.
- R8: `irq_out` is registered: in each cycle it equals (pending AND enable) as it stood one clock earlier.
- R9: Reads from any unmapped offset return 0, and writes to unmapped offsets change no register.
- R10: The enable offset is a parameter. With a value of 0x34 the enable lives at 0x34, and 0x08 behaves as unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, acts at the rising clock edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| nmi_pin | input | 1 | Asynchronous NMI input |
| irq_out | output | 1 | Registered request to the parent controller |

## Verification
Several properties are checked on every cycle: the one-cycle registered relation between pending, enable and `irq_out`, the holding of an edge-latched flag when no clear arrives, the drop of a level flag on a clear, the capture of the enable bit, the immunity of the registers to unmapped writes, and the reset values. Other behaviour can only be shown by the bench's scenarios against its cycle-level model. These include the exact two-stage synchroniser latency, the same-cycle race between an edge and a clear, the re-assertion of a still-active level after an acknowledge, the changes between trigger codes, and the relocation of the enable register to its second offset.

// File: rtl/nmi_trig_pkg.sv
package nmi_trig_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_LO    = 2'd0,
        TRIG_EDGE_FALL = 2'd1,
        TRIG_LVL_HI    = 2'd2,
        TRIG_EDGE_RISE = 2'd3
    } trig_e;

    localparam int unsigned CTRL_OFS = 32'h00;
    localparam int unsigned PEND_OFS = 32'h04;

    typedef struct packed {
        logic ctrl_wr;
        logic en_wr;
        logic pend_clr;
    } wr_dec_t;

    typedef struct packed {
        logic lvl_act;
        logic edge_evt;
    } trig_hit_t;

    // Odd trigger codes are the edge-sensitive ones.
    function automatic logic trig_is_edge(trig_e t);
        return t[0];
    endfunction

endpackage

// File: rtl/nmi_trig_sync.sv
module nmi_trig_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic lvl,
    output logic lvl_prev
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= RST_VAL;
                else     chain[0] <= pin;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= chain[STAGES-1];
    end

    assign lvl      = chain[STAGES-1];
    assign lvl_prev = prev_q;
endmodule

// File: rtl/nmi_trig_detect.sv
module nmi_trig_detect
    import nmi_trig_pkg::*;
(
    input  trig_e     mode,
    input  logic      lvl,
    input  logic      lvl_prev,
    output trig_hit_t hit
);
    always_comb begin
        hit = '0;
        unique case (mode)
            TRIG_LVL_LO:    hit.lvl_act  = ~lvl;
            TRIG_LVL_HI:    hit.lvl_act  = lvl;
            TRIG_EDGE_FALL: hit.edge_evt = lvl_prev & ~lvl;
            TRIG_EDGE_RISE: hit.edge_evt = ~lvl_prev & lvl;
            default:        hit = '0;
        endcase
    end
endmodule

// File: rtl/nmi_trig_regs.sv
module nmi_trig_regs
    import nmi_trig_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter int unsigned EN_OFFSET = 32'h08
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pend_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              en_q,
    output logic              pend_clr
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_OFS);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_OFFSET);

    wr_dec_t dec;

    always_comb begin
        dec          = '0;
        dec.ctrl_wr  = bus_we && (bus_addr == A_CTRL);
        dec.en_wr    = bus_we && (bus_addr == A_EN);
        dec.pend_clr = bus_we && (bus_addr == A_PEND) && bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            en_q   <= 1'b0;
        end else begin
            if (dec.ctrl_wr) ctrl_q <= bus_wdata;
            if (dec.en_wr)   en_q   <= bus_wdata[0];
        end
    end

    assign pend_clr = dec.pend_clr;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)      bus_rdata    = ctrl_q;
        else if (bus_addr == A_PEND) bus_rdata[0] = pend_q;
        else if (bus_addr == A_EN)   bus_rdata[0] = en_q;
    end
endmodule

// File: rtl/nmi_trig_unit.sv
module nmi_trig_unit
    import nmi_trig_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter int unsigned EN_OFFSET = 32'h08,
    parameter int          SYNC_LEN  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              nmi_pin,
    output logic              irq_out
);
    logic [DATA_W-1:0] ctrl_q;
    logic              en_q;
    logic              pend_q;
    logic              pend_clr;
    logic              lvl;
    logic              lvl_prev;
    logic              irq_q;
    trig_e             mode;
    trig_hit_t         hit;

    assign mode = trig_e'(ctrl_q[1:0]);

    nmi_trig_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_OFFSET(EN_OFFSET)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend_q(pend_q), .ctrl_q(ctrl_q), .en_q(en_q), .pend_clr(pend_clr)
    );

    nmi_trig_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .pin(nmi_pin), .lvl(lvl), .lvl_prev(lvl_prev)
    );

    nmi_trig_detect u_det (
        .mode(mode), .lvl(lvl), .lvl_prev(lvl_prev), .hit(hit)
    );

    // Edge modes latch and win against a same-cycle clear; level modes track.
    always_ff @(posedge clk) begin
        if (rst)                     pend_q <= 1'b0;
        else if (trig_is_edge(mode)) pend_q <= hit.edge_evt | (pend_q & ~pend_clr);
        else                         pend_q <= hit.lvl_act & ~pend_clr;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= pend_q & en_q;
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/nmi_trig_chk.sv
module nmi_trig_chk #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter int unsigned EN_OFFSET = 32'h08
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              wbit0,
    input logic [DATA_W-1:0] ctrl_q,
    input logic              en_q,
    input logic              pend_q,
    input logic              irq_out
);
    logic clr_wr;
    logic unmapped_wr;
    assign clr_wr      = bus_we && (bus_addr == ADDR_W'(32'h04)) && wbit0;
    assign unmapped_wr = bus_we && (bus_addr != ADDR_W'(32'h00))
                       && (bus_addr != ADDR_W'(32'h04))
                       && (bus_addr != ADDR_W'(EN_OFFSET));

    assert_reset_vals_R1: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0 && !en_q && !pend_q && !irq_out));

    assert_edge_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[0] && pend_q && !clr_wr) |=> pend_q);

    assert_level_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[0] && clr_wr) |=> !pend_q);

    assert_en_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(EN_OFFSET)) |=> (en_q == $past(wbit0)));

    assert_irq_set_R8: assert property (@(posedge clk) disable iff (rst)
        (pend_q && en_q) |=> irq_out);

    assert_irq_clr_R8: assert property (@(posedge clk) disable iff (rst)
        !(pend_q && en_q) |=> !irq_out);

    assert_unmapped_wr_R9: assert property (@(posedge clk) disable iff (rst)
        unmapped_wr |=> ($stable(ctrl_q) && $stable(en_q)));
endmodule

bind nmi_trig_unit nmi_trig_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_OFFSET(EN_OFFSET)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .wbit0(bus_wdata[0]), .ctrl_q(ctrl_q), .en_q(en_q),
    .pend_q(pend_q), .irq_out(irq_out)
);

// File: tb/sim_nmi_trig_unit.sv
`timescale 1ns/100ps
module sim_nmi_trig_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata1;
    logic        nmi_pin = 1'b1;
    logic        irq_out, irq1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk; // 250 MHz

    nmi_trig_unit u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nmi_pin(nmi_pin), .irq_out(irq_out)
    );

    nmi_trig_unit #(.EN_OFFSET(32'h34)) u1 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1),
        .nmi_pin(nmi_pin), .irq_out(irq1)
    );

    // Behavioural cycle model of u0
    logic [31:0] m_ctrl;
    logic        m_en, m_pend, m_irq, m_s1, m_s2, m_prev;

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_en = 0; m_pend = 0; m_irq = 0;
            m_s1 = 1; m_s2 = 1; m_prev = 1;
        end else begin
            int  code;
            bit  active, evt, clr;
            code   = int'(m_ctrl[1:0]);
            active = (code == 0 && !m_s2) || (code == 2 && m_s2);
            evt    = (code == 1 && m_prev && !m_s2) || (code == 3 && !m_prev && m_s2);
            clr    = bus_we && bus_addr == 8'h04 && bus_wdata[0];
            m_irq  = m_pend && m_en;
            if (code == 1 || code == 3) m_pend = evt || (m_pend && !clr);
            else                        m_pend = active && !clr;
            if (bus_we && bus_addr == 8'h00) m_ctrl = bus_wdata;
            if (bus_we && bus_addr == 8'h08) m_en = bus_wdata[0];
            m_prev = m_s2; m_s2 = m_s1; m_s1 = nmi_pin;
        end
    end

    function automatic logic [31:0] m_read(logic [7:0] a);
        if (a == 8'h00) return m_ctrl;
        if (a == 8'h04) return {31'b0, m_pend};
        if (a == 8'h08) return {31'b0, m_en};
        return 32'h0;
    endfunction

    function automatic string tag_of(logic [7:0] a);
        if (a == 8'h00) return "R2";
        if (a == 8'h04) return "R4";
        if (a == 8'h08) return "R7";
        return "R9";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
            chk("R8", {31'b0, irq_out}, {31'b0, m_irq});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic go(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        go(1);
        bus_we = 0; bus_wdata = '0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        go(4);
        rst = 0;
        go(1);
        // R1 reset state
        rd(8'h00, 32'h0, "R1");
        rd(8'h04, 32'h0, "R1");
        rd(8'h08, 32'h0, "R1");
        chk("R1", {31'b0, irq_out}, 32'h0);

        // R2 control storage, rising mode
        wr(8'h00, 32'hABCD_0003);
        rd(8'h00, 32'hABCD_0003, "R2");
        // R7 enable bit only
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h1, "R7");

        // R3 latency of rising edge
        nmi_pin = 0; go(4);
        bus_addr = 8'h04;
        nmi_pin = 1;
        go(2); rd(8'h04, 32'h0, "R3");
        go(1); rd(8'h04, 32'h1, "R3");
        chk("R8", {31'b0, irq_out}, 32'h0);
        go(1); chk("R8", {31'b0, irq_out}, 32'h1);

        // R4 latch until cleared; zero write ignored
        nmi_pin = 0; go(4);
        rd(8'h04, 32'h1, "R4");
        wr(8'h04, 32'h0); rd(8'h04, 32'h1, "R4");

        // R6 event and clear in the same cycle
        nmi_pin = 1; go(2);
        wr(8'h04, 32'h1);
        rd(8'h04, 32'h1, "R6");
        wr(8'h04, 32'h1);
        rd(8'h04, 32'h0, "R4");
        go(1); chk("R8", {31'b0, irq_out}, 32'h0);

        // R4 falling edge mode
        wr(8'h00, 32'h1); go(3);
        nmi_pin = 0; go(3);
        rd(8'h04, 32'h1, "R4");
        nmi_pin = 1; go(4);
        rd(8'h04, 32'h1, "R4");
        wr(8'h04, 32'h1); rd(8'h04, 32'h0, "R4");

        // R5 level high
        nmi_pin = 0; go(3);
        wr(8'h00, 32'h2); go(1);
        rd(8'h04, 32'h0, "R5");
        nmi_pin = 1; go(3);
        rd(8'h04, 32'h1, "R5");
        wr(8'h04, 32'h1); rd(8'h04, 32'h0, "R5");
        go(1); rd(8'h04, 32'h1, "R5");
        nmi_pin = 0; go(2);
        rd(8'h04, 32'h1, "R5");
        go(1); rd(8'h04, 32'h0, "R5");

        // R5 level low
        wr(8'h00, 32'h0); rd(8'h04, 32'h0, "R5");
        go(1); rd(8'h04, 32'h1, "R5");
        go(1); chk("R8", {31'b0, irq_out}, 32'h1);

        // R7/R8 masking drops the request one cycle later
        wr(8'h08, 32'h0);
        chk("R8", {31'b0, irq_out}, 32'h1);
        go(1); chk("R7", {31'b0, irq_out}, 32'h0);
        rd(8'h04, 32'h1, "R7");
        wr(8'h08, 32'h1); go(1);
        chk("R7", {31'b0, irq_out}, 32'h1);
        nmi_pin = 1; go(4);

        // R9 unmapped accesses
        wr(8'h00, 32'h1234_5672);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h34, 32'h0);
        rd(8'h10, 32'h0, "R9");
        rd(8'h34, 32'h0, "R9");
        rd(8'h00, 32'h1234_5672, "R9");
        rd(8'h08, 32'h1, "R9");

        // R10 relocated enable on u1
        wr(8'h34, 32'h1);
        bus_addr = 8'h34; #0.5; chk("R10", rdata1, 32'h1);
        bus_addr = 8'h08; #0.5; chk("R10", rdata1, 32'h0);
        go(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule